// File: doc/BRIEF.md
# Watermarked Receive Byte FIFO

This block buffers bytes arriving from an I2C byte engine until a register interface collects them. It holds up to sixteen bytes in arrival order. The engine side offers one byte per cycle on a push strobe. The register side pops one byte per read strobe, reads a zero-based occupancy value and a status byte, and writes a zero-based fill threshold.

A level output, the receive-full event, is high whenever the number of stored bytes is at least the threshold plus one. Interrupt logic can therefore be told to wait for a chosen batch size rather than for a completely full queue. Software may change the threshold at any time, and the event follows the new value from the next cycle.

A push that arrives while the queue is full is lost and sets a sticky overflow flag. A soft clear input returns the queue to empty, the threshold to zero and the overflow flag to clear, without a full reset.

Top module: `rxq_wm_fifo`

## Requirements
- R1: The queue stores up to DEPTH (default 16) bytes and returns them in the order they were pushed.
- R2: `occ_q` equals the number of stored bytes minus one while the queue holds at least one byte, and reads 0 when it is empty.
- R3: `status` bit 6 is 1 exactly when the queue is empty, bit 5 is 1 exactly when it holds DEPTH bytes, and all other status bits read 0.
- R4: `rxfull_evt` is 1 exactly when the stored count is at least `thr_q` + 1. A threshold write is visible on `thr_q` and reflected in `rxfull_evt` in the cycle after the write edge.
- R5: A `pop` pulse on a non-empty queue removes the oldest byte and places it on `rd_data` in the cycle after the edge.
- R6: A `pop` on an empty queue leaves `rd_data` at its previous value and leaves the queue empty.
- R7: A `push_vld` while the queue holds DEPTH bytes is dropped, even if a pop happens in the same cycle, and sets `ovf`. `ovf` then stays 1 until a reset or soft clear.
- R8: `soft_clr` empties the queue, sets the threshold to 0 and clears `ovf`. It takes priority over a push, pop or threshold write in the same cycle.
- R9: While `rst_n` is low at a clock edge, the block goes to empty, threshold 0, `ovf` 0 and `rd_data` 0.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full both take effect and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_clr | input | 1 | Soft clear: empty the queue, zero the threshold, clear overflow |
| push_vld | input | 1 | Byte-engine push strobe |
| push_data | input | 8 | Byte to store |
| pop | input | 1 | Register-side read strobe that removes one byte |
| rd_data | output | 8 | Last popped byte |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | 4 | Zero-based threshold value |
| thr_q | output | 4 | Current threshold |
| occ_q | output | 4 | Zero-based occupancy |
| status | output | 8 | Bit 6 empty, bit 5 full, other bits 0 |
| rxfull_evt | output | 1 | Level event: count is at least threshold + 1 |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A count register that slips by one shows up on `occ_q`, the two status flags and `rxfull_evt` in the very next cycle. It also shows up later as a missing or extra byte when the queue is drained. A pointer that wraps wrongly stays hidden until the queue has cycled past its last slot, and then appears as out-of-order bytes on `rd_data`. The bench sweeps every threshold across every fill level so that an off-by-one compare is caught at its exact boundary, and it drains after every wrap to expose pointer faults.

// File: rtl/rxq_pkg.sv
// Package: shared widths and status bit positions for the receive queue.
// Assumes: status bit positions are decoded by the register file.
package rxq_pkg;
    localparam int RXQ_STAT_W     = 8;
    localparam int RXQ_EMPTY_BIT  = 6;
    localparam int RXQ_FULL_BIT   = 5;

    typedef struct packed {
        logic empty;
        logic full;
    } rxq_flags_t;
endpackage

// File: rtl/rxq_store.sv
// Module: byte storage with circular read and write pointers.
// Assumes: wr_en and rd_en are only raised when legal (not full / not empty),
// which the top guarantees; clr has priority over both.
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en,
    output logic [DW-1:0] rdata
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    // Advance a pointer with wrap at the last slot.
    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Write accepted bytes into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en && !clr && rst_n) begin
            mem[wptr] <= wdata;
        end
    end

    // Move pointers and capture the popped byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            rdata <= '0;
        end else if (clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_en) wptr <= nxt(wptr);
            if (rd_en) begin
                rptr  <= nxt(rptr);
                rdata <= mem[rptr];
            end
        end
    end

    // R6
    no_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/rxq_level.sv
// Module: fill count, threshold register, flags, watermark event, overflow.
// Assumes: inc is never raised when full and dec never when empty; drop marks
// a push refused because of a full queue.
module rxq_level #(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          dec,
    input  logic          drop,
    input  logic          thr_wr,
    input  logic [AW-1:0] thr_wdata,
    output logic [AW-1:0] thr,
    output logic [AW-1:0] occ,
    output rxq_pkg::rxq_flags_t flags,
    output logic          evt,
    output logic          ovf
);
    localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

    logic [CW-1:0] count;

    // Track stored byte count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && !dec) begin
            count <= count + 1'b1;
        end else if (dec && !inc) begin
            count <= count - 1'b1;
        end
    end

    // Hold the zero-based threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            thr <= '0;
        end else if (thr_wr) begin
            thr <= thr_wdata;
        end
    end

    // Sticky overflow on a refused push.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ovf <= 1'b0;
        end else if (drop) begin
            ovf <= 1'b1;
        end
    end

    // Derive occupancy, flags and the watermark event.
    always_comb begin
        occ         = (count == '0) ? '0 : AW'(count - 1'b1);
        flags.empty = (count == '0);
        flags.full  = (count == FULLCNT);
        evt         = (count > CW'(thr));
    end

    // R1
    cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULLCNT);
    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !clr |=> ovf);
    // R8
    clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> flags.empty && thr == '0 && !ovf);
endmodule

// File: rtl/rxq_wm_fifo.sv
// Module: top of the watermarked receive queue. Gates push and pop against
// the flags, assembles the status byte and wires the storage and level parts.
// Assumes: synchronous active-low reset; one push and one pop per cycle at most.
module rxq_wm_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          push_vld,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    input  logic          thr_wr,
    input  logic [AW-1:0] thr_wdata,
    output logic [AW-1:0] thr_q,
    output logic [AW-1:0] occ_q,
    output logic [rxq_pkg::RXQ_STAT_W-1:0] status,
    output logic          rxfull_evt,
    output logic          ovf
);
    import rxq_pkg::*;

    rxq_flags_t flags;
    logic       acc_push, acc_pop, drop;

    // Qualify the strobes against current flags and the soft clear.
    always_comb begin
        acc_push = push_vld && !flags.full  && !soft_clr;
        acc_pop  = pop      && !flags.empty && !soft_clr;
        drop     = push_vld &&  flags.full  && !soft_clr;
    end

    // Assemble the status byte at its fixed bit positions.
    always_comb begin
        status                = '0;
        status[RXQ_EMPTY_BIT] = flags.empty;
        status[RXQ_FULL_BIT]  = flags.full;
    end

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_clr),
        .wr_en (acc_push),
        .wdata (push_data),
        .rd_en (acc_pop),
        .rdata (rd_data)
    );

    rxq_level #(.DEPTH(DEPTH)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_clr),
        .inc       (acc_push),
        .dec       (acc_pop),
        .drop      (drop),
        .thr_wr    (thr_wr),
        .thr_wdata (thr_wdata),
        .thr       (thr_q),
        .occ       (occ_q),
        .flags     (flags),
        .evt       (rxfull_evt),
        .ovf       (ovf)
    );

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop && flags.empty && !soft_clr |=> $stable(rd_data) && flags.empty == !$past(push_vld));
    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld && flags.full && !pop && !soft_clr |=> flags.full && ovf);
    // R10
    both_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld && pop && !flags.full && !flags.empty && !soft_clr |=> $stable(occ_q));
endmodule

// File: tb/rxq_wm_fifo_tb.sv
module rxq_wm_fifo_tb;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n, soft_clr, push_vld, pop, thr_wr;
    logic [7:0] push_data, rd_data, status;
    logic [3:0] thr_wdata, thr_q, occ_q;
    logic       rxfull_evt, ovf;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Requirement model.
    int m_q[$];
    int m_thr  = 0;
    int m_ovf  = 0;
    int m_last = 0;
    int nb     = 0;

    always #2 clk = ~clk;

    rxq_wm_fifo #(.DEPTH(DEPTH), .DW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .push_vld(push_vld), .push_data(push_data), .pop(pop),
        .rd_data(rd_data), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
        .thr_q(thr_q), .occ_q(occ_q), .status(status),
        .rxfull_evt(rxfull_evt), .ovf(ovf)
    );

    task automatic chk(input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", rq, act, exp, $time);
        end
    endtask

    // Compare all level outputs with the model.
    task automatic chk_all();
        int n = m_q.size();
        chk("R2 occ", int'(occ_q), (n == 0) ? 0 : n - 1);
        chk("R3 status", int'(status), (n == 0 ? 8'h40 : 8'h00) | (n == DEPTH ? 8'h20 : 8'h00));
        chk("R4 evt", int'(rxfull_evt), (n >= m_thr + 1) ? 1 : 0);
        chk("R4 thr", int'(thr_q), m_thr);
        chk("R7 ovf", int'(ovf), m_ovf);
    endtask

    // One clock with given strobes; the model follows the requirements.
    task automatic cyc(input bit p, input int d, input bit r, input bit tw,
                       input int tv, input bit c);
        int n0 = m_q.size();
        push_vld = p; push_data = 8'(d); pop = r;
        thr_wr = tw; thr_wdata = 4'(tv); soft_clr = c;
        @(posedge clk);
        #1;
        push_vld = 0; pop = 0; thr_wr = 0; soft_clr = 0;
        if (c) begin
            m_q.delete(); m_thr = 0; m_ovf = 0;
        end else begin
            if (r && n0 > 0) m_last = m_q.pop_front();
            if (p) begin
                if (n0 < DEPTH) m_q.push_back(d);
                else m_ovf = 1;
            end
            if (tw) m_thr = tv;
        end
    endtask

    task automatic push_b(input int d); cyc(1, d, 0, 0, 0, 0); endtask
    task automatic pop_b();             cyc(0, 0, 1, 0, 0, 0); endtask

    // Drain everything, checking order after every pop (R1, R5).
    task automatic drain();
        while (m_q.size() > 0) begin
            pop_b();
            chk("R5 rd_data", int'(rd_data), m_last);
            chk_all();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; soft_clr = 0; push_vld = 0; pop = 0; thr_wr = 0;
        push_data = 0; thr_wdata = 0;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state.
        chk("R9 rd_data", int'(rd_data), 0);
        chk_all();
        rst_n = 1;

        // R4 sweep: every threshold across every fill level.
        for (int t = 0; t < DEPTH; t++) begin
            cyc(0, 0, 0, 1, t, 0);
            chk_all();
            for (int k = 0; k < DEPTH; k++) begin
                push_b((t * 17 + k * 5 + 3) & 8'hff);
                chk_all();
            end
            drain();
            cyc(0, 0, 0, 0, 0, 1);
            chk_all();
        end

        // R7: overflow on full, also with a same-cycle pop.
        for (int k = 0; k < DEPTH; k++) push_b(8'h80 + k);
        chk_all();
        push_b(8'hEE);
        chk("R7 full kept", int'(status), 8'h20);
        chk_all();
        cyc(1, 8'hDD, 1, 0, 0, 0);
        chk("R7 pop while full drop", int'(rd_data), 8'h80);
        chk_all();
        drain();
        chk("R7 ovf sticky after drain", int'(ovf), 1);

        // R6: pop while empty holds rd_data.
        nb = int'(rd_data);
        pop_b();
        chk("R6 rd_data hold", int'(rd_data), nb);
        chk_all();

        // R8: soft clear wins over push and threshold write.
        push_b(8'h11); push_b(8'h22);
        cyc(0, 0, 0, 1, 9, 0);
        cyc(1, 8'h33, 1, 1, 5, 1);
        chk("R8 cleared", int'(status), 8'h40);
        chk_all();

        // R10: simultaneous push/pop across pointer wrap.
        for (int k = 0; k < 3; k++) push_b(8'h40 + k);
        for (int k = 0; k < 40; k++) begin
            cyc(1, (k * 7) & 8'hff, 1, 0, 0, 0);
            chk("R10 rd_data", int'(rd_data), m_last);
            chk_all();
        end
        drain();

        // R4: rewriting threshold at a fixed fill.
        for (int k = 0; k < 5; k++) push_b(k);
        for (int t = 0; t < DEPTH; t++) begin
            cyc(0, 0, 0, 1, t, 0);
            chk("R4 rewrite", int'(rxfull_evt), (5 >= t + 1) ? 1 : 0);
        end

        // R9: synchronous reset mid-use.
        rst_n = 0;
        @(posedge clk); #1;
        m_q.delete(); m_thr = 0; m_ovf = 0;
        chk("R9 rd_data", int'(rd_data), 0);
        chk_all();
        rst_n = 1;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule